// File: doc/BRIEF.md
# Pattern-Independent Serial Frame Lock Detector

This block sits behind a clock-and-data recovery stage that already delivers one recovered bit per fast-clock cycle. It finds where each 28-bit frame starts and needs no reference clock, training sequence or sync character. It does this by watching every possible bit offset for the fixed clock marker: a 1 at the first position of a frame and a 0 at the last. Because that marker appears in every frame whatever the payload carries, the search works for any data pattern.

Once one offset has shown the marker in enough consecutive frames, the detector declares lock. From then on it decodes one frame per 28 cycles:
- The DC-balance bit tells it whether to invert the 24 payload bits.
- The integrity bit, checked against the parity of the corrected payload, tells it whether the frame is active pixel data, a blanking frame carrying the sync controls, or corrupt.

The block has a two-state controller:
- SEARCH: the detector hunts for an offset.
- LOCKED: the detector decodes frames.

It has two transitions:
- ACQUIRE: from SEARCH to LOCKED, when an offset completes its run of good markers.
- LOSE: from LOCKED to SEARCH, when the marker is absent from too many consecutive frames at the locked offset.

Top module: `fld_lock_top`

## Requirements
- R1: Frame layout, in arrival order. Position 0 is the marker bit, which is 1. Positions 1..24 are payload bits 0..23, least significant first. Position 25 is the integrity bit. Position 26 is the inversion bit. Position 27 is the marker bit, which is 0.
- R2: In SEARCH, an offset whose marker pair is correct in LOCK_FRAMES (32) consecutive frames causes ACQUIRE. The lock output rises on the clock edge after the edge that shifts in the last bit of that 32nd frame. This holds for any payload content and any starting offset.
- R3: A single frame with a broken marker at the candidate offset restarts that offset's count from zero. After the break, a full 32 further good frames are needed.
- R4: In LOCKED, a frame with a missing marker at the locked offset increments a miss count, and a good marker clears it. LOSE happens on the MISS_FRAMES-th (4th) consecutive missing marker. Three misses followed by a good frame keep lock.
- R5: When the inversion bit is 1, the 24 received payload bits are inverted before parity checking and output. When it is 0, they are used as received.
- R6: A locked frame whose integrity bit differs from the XOR of the corrected payload is an active frame. It sets pix_data to the payload, sets ctl_de to 1, and pulses pix_valid for exactly one cycle, one edge after the frame's last bit is shifted in.
- R7: A locked frame whose integrity bit equals the XOR of the corrected payload, and whose payload bits 23..2 are all zero, is a blanking frame. It sets ctl_de to 0, ctl_hs to payload bit 0 and ctl_vs to payload bit 1, and it gives no valid pulse.
- R8: A locked frame with an integrity bit equal to the payload XOR and some payload bit in 23..2 set is corrupt. It pulses par_err for one cycle and leaves pix_data, ctl_de, ctl_hs and ctl_vs unchanged.
- R9: While the lock output is low, pix_valid and par_err stay 0, and pix_data, ctl_de, ctl_hs and ctl_vs hold their last values.
- R10: During reset, all outputs are 0.
- R11: A frame with a missing marker while locked is not decoded: no valid pulse, no error pulse, and no output change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock, one recovered bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Recovered serial bit |
| pix_data | output | 24 | Last decoded active payload word |
| pix_valid | output | 1 | One-cycle strobe for a new active word |
| ctl_de | output | 1 | Data-enable, 1 after an active frame, 0 after a blanking frame |
| ctl_hs | output | 1 | Horizontal sync from the last blanking frame |
| ctl_vs | output | 1 | Vertical sync from the last blanking frame |
| frm_lock | output | 1 | High while in LOCKED |
| par_err | output | 1 | One-cycle strobe for a corrupt frame |

## Verification
The bench goes after the count boundaries.

Lock must not appear after 31 frames when a broken marker sits just before them, and it must appear after the 32nd. A design that failed to clear the count on a break would lock early. One that counted off by one would lock a frame early or late.

Three missing frames must keep lock and four must drop it. Missed frames must not be decoded. A design that never reset its miss count, or that decoded markerless frames, would emit spurious valid pulses or drop lock too soon.

Inverted payloads, blanking frames and corrupt frames are mixed with random data. The bench also moves the stream by a few bits to force a relock at a new offset. This catches a wrong inversion polarity, a swapped sync bit, an error pulse that also changes the outputs, and an offset register that is never reloaded.

// File: rtl/fld_pkg.sv
package fld_pkg;

    localparam int FRAME_LEN = 28;
    localparam int PAY_W     = FRAME_LEN - 4;
    localparam int PH_W      = $clog2(FRAME_LEN);

    typedef enum logic [0:0] {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

    typedef enum logic [1:0] {
        FK_ACTIVE  = 2'd0,
        FK_CONTROL = 2'd1,
        FK_BAD     = 2'd2
    } frame_kind_e;

    typedef struct packed {
        logic [PAY_W-1:0] word;
        logic             chk;
        logic             inv;
        logic             mark;
    } frame_view_t;

endpackage

// File: rtl/fld_shift_phase.sv
module fld_shift_phase
    import fld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    output frame_view_t       view,
    output logic [PH_W-1:0]   phase
);

    logic [FRAME_LEN-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            phase <= '0;
        end else begin
            sr_q  <= {sr_q[FRAME_LEN-2:0], ser_bit};
            if (phase == PH_W'(FRAME_LEN - 1)) begin
                phase <= '0;
            end else begin
                phase <= phase + PH_W'(1);
            end
        end
    end

    // oldest bit sits at the top of the window; payload bit i arrived at position 1+i
    for (genvar i = 0; i < PAY_W; i++) begin : g_pay
        assign view.word[i] = sr_q[FRAME_LEN-2-i];
    end

    assign view.chk  = sr_q[2];
    assign view.inv  = sr_q[1];
    assign view.mark = sr_q[FRAME_LEN-1] & ~sr_q[0];

endmodule

// File: rtl/fld_cand_bank.sv
module fld_cand_bank
    import fld_pkg::*;
#(
    parameter int LOCK_FRAMES = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            clear,
    input  logic [PH_W-1:0] phase,
    input  logic            mark,
    output logic            hit
);

    localparam int CW = $clog2(LOCK_FRAMES + 1);

    logic [FRAME_LEN-1:0] hit_vec;

    for (genvar k = 0; k < FRAME_LEN; k++) begin : g_cand
        logic [CW-1:0] run_q;
        logic          mine;

        assign mine       = enable && (phase == PH_W'(k));
        assign hit_vec[k] = mine && mark && (run_q == CW'(LOCK_FRAMES - 1));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_q <= '0;
            end else if (clear) begin
                run_q <= '0;
            end else if (mine) begin
                run_q <= mark ? run_q + CW'(1) : '0;
            end
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/fld_frame_decode.sv
module fld_frame_decode
    import fld_pkg::*;
(
    input  frame_view_t       view,
    output logic [PAY_W-1:0]  word,
    output frame_kind_e       kind
);

    logic par;

    always_comb begin
        word = view.inv ? ~view.word : view.word;
        par  = ^word;
        if (view.chk != par) begin
            kind = FK_ACTIVE;
        end else if (word[PAY_W-1:2] == '0) begin
            kind = FK_CONTROL;
        end else begin
            kind = FK_BAD;
        end
    end

endmodule

// File: rtl/fld_lock_top.sv
module fld_lock_top
    import fld_pkg::*;
#(
    parameter int LOCK_FRAMES = 32,
    parameter int MISS_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    output logic [PAY_W-1:0]  pix_data,
    output logic              pix_valid,
    output logic              ctl_de,
    output logic              ctl_hs,
    output logic              ctl_vs,
    output logic              frm_lock,
    output logic              par_err
);

    localparam int MW = (MISS_FRAMES > 2) ? $clog2(MISS_FRAMES) : 1;

    lock_state_e      state_q, state_d;
    frame_view_t      view;
    logic [PH_W-1:0]  phase;
    logic [PH_W-1:0]  lock_ph_q;
    logic [MW-1:0]    miss_q;
    logic             hit;
    logic             at_slot;
    logic             take_lock, drop_lock, decode_en;
    logic [PAY_W-1:0] dec_word;
    frame_kind_e      dec_kind;

    fld_shift_phase u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_bit (ser_bit),
        .view    (view),
        .phase   (phase)
    );

    fld_cand_bank #(.LOCK_FRAMES(LOCK_FRAMES)) u_cand (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (state_q == ST_SEARCH),
        .clear  (take_lock),
        .phase  (phase),
        .mark   (view.mark),
        .hit    (hit)
    );

    fld_frame_decode u_dec (
        .view (view),
        .word (dec_word),
        .kind (dec_kind)
    );

    assign at_slot = (phase == lock_ph_q);

    // next state and transition strobes
    always_comb begin
        state_d   = state_q;
        take_lock = 1'b0;
        drop_lock = 1'b0;
        decode_en = 1'b0;
        unique case (state_q)
            ST_SEARCH: begin
                if (hit) begin
                    state_d   = ST_LOCKED;
                    take_lock = 1'b1;
                end
            end
            ST_LOCKED: begin
                if (at_slot) begin
                    if (view.mark) begin
                        decode_en = 1'b1;
                    end else if (miss_q == MW'(MISS_FRAMES - 1)) begin
                        state_d   = ST_SEARCH;
                        drop_lock = 1'b1;
                    end
                end
            end
        endcase
    end

    // state register with offset and miss tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_SEARCH;
            lock_ph_q <= '0;
            miss_q    <= '0;
        end else begin
            state_q <= state_d;
            if (take_lock) begin
                lock_ph_q <= phase;
            end
            if (take_lock || drop_lock) begin
                miss_q <= '0;
            end else if (state_q == ST_LOCKED && at_slot) begin
                miss_q <= view.mark ? '0 : miss_q + MW'(1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_data  <= '0;
            pix_valid <= 1'b0;
            ctl_de    <= 1'b0;
            ctl_hs    <= 1'b0;
            ctl_vs    <= 1'b0;
            par_err   <= 1'b0;
        end else begin
            pix_valid <= 1'b0;
            par_err   <= 1'b0;
            if (decode_en) begin
                unique case (dec_kind)
                    FK_ACTIVE: begin
                        pix_data  <= dec_word;
                        pix_valid <= 1'b1;
                        ctl_de    <= 1'b1;
                    end
                    FK_CONTROL: begin
                        ctl_de <= 1'b0;
                        ctl_hs <= dec_word[0];
                        ctl_vs <= dec_word[1];
                    end
                    default: begin
                        par_err <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign frm_lock = (state_q == ST_LOCKED);

endmodule

// File: rtl/fld_lock_chk.sv
module fld_lock_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] pix_data,
    input logic        pix_valid,
    input logic        ctl_de,
    input logic        ctl_hs,
    input logic        ctl_vs,
    input logic        frm_lock,
    input logic        par_err
);

    p_valid_needs_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> frm_lock);

    p_err_needs_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> frm_lock);

    p_hold_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_lock |-> $stable({pix_data, ctl_de, ctl_hs, ctl_vs}));

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);

    p_valid_de_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> ctl_de);

    p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> !par_err);

    p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_err && pix_valid));

    p_err_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $stable({pix_data, ctl_de, ctl_hs, ctl_vs}));

endmodule

bind fld_lock_top fld_lock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_data  (pix_data),
    .pix_valid (pix_valid),
    .ctl_de    (ctl_de),
    .ctl_hs    (ctl_hs),
    .ctl_vs    (ctl_vs),
    .frm_lock  (frm_lock),
    .par_err   (par_err)
);

// File: tb/tb_fld_lock_top.sv
module tb_fld_lock_top;

    localparam int FL    = 28;
    localparam int LOCKN = 32;
    localparam int MISSN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_bit = 1'b0;
    logic [23:0] pix_data;
    logic        pix_valid, ctl_de, ctl_hs, ctl_vs, frm_lock, par_err;

    always #4 clk = ~clk;

    fld_lock_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_bit   (ser_bit),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .ctl_de    (ctl_de),
        .ctl_hs    (ctl_hs),
        .ctl_vs    (ctl_vs),
        .frm_lock  (frm_lock),
        .par_err   (par_err)
    );

    int    checks = 0;
    int    errors = 0;
    string scen   = "R10 reset";

    // behavioural reference state
    int          hist[$];
    int          m_ph = 0;
    int          cand[FL];
    bit          m_lock = 0;
    int          m_lph = 0;
    int          m_miss = 0;
    logic [23:0] e_data = '0;
    bit          e_valid = 0, e_de = 0, e_hs = 0, e_vs = 0, e_err = 0;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s [%s]: got %0h expected %0h", tag, scen, got, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 R4 lock",  32'(frm_lock),  32'(m_lock));
        chk("R6 R11 valid", 32'(pix_valid), 32'(e_valid));
        chk("R1 R5 data",  32'(pix_data),  32'(e_data));
        chk("R7 de",       32'(ctl_de),    32'(e_de));
        chk("R7 hs",       32'(ctl_hs),    32'(e_hs));
        chk("R7 vs",       32'(ctl_vs),    32'(e_vs));
        chk("R8 err",      32'(par_err),   32'(e_err));
    endtask

    // one rising edge of the reference, using the window before the new bit
    task automatic model_edge(bit b);
        bit          mk;
        bit          inv, integ;
        logic [23:0] t;
        mk = (hist[0] == 1) && (hist[FL-1] == 0);
        e_valid = 0;
        e_err   = 0;
        if (!m_lock) begin
            if (mk) begin
                if (cand[m_ph] == LOCKN - 1) begin
                    m_lock = 1;
                    m_lph  = m_ph;
                    m_miss = 0;
                    for (int k = 0; k < FL; k++) cand[k] = 0;
                end else begin
                    cand[m_ph]++;
                end
            end else begin
                cand[m_ph] = 0;
            end
        end else if (m_ph == m_lph) begin
            if (mk) begin
                m_miss = 0;
                inv   = hist[26][0];
                integ = hist[25][0];
                for (int i = 0; i < 24; i++) t[i] = hist[1+i][0] ^ inv;
                if (integ != ^t) begin
                    e_data = t; e_valid = 1; e_de = 1;
                end else if (t[23:2] == 0) begin
                    e_de = 0; e_hs = t[0]; e_vs = t[1];
                end else begin
                    e_err = 1;
                end
            end else if (m_miss == MISSN - 1) begin
                m_lock = 0;
                m_miss = 0;
            end else begin
                m_miss++;
            end
        end
        m_ph = (m_ph + 1) % FL;
        hist.push_back(int'(b));
        void'(hist.pop_front());
    endtask

    task automatic step(bit b);
        @(negedge clk);
        compare_all();
        ser_bit = b;
        model_edge(b);
    endtask

    // kind: 0 active, 1 blanking, 2 corrupt; lock_exp checks the previous frame's lock result
    task automatic send_frame(logic [23:0] t, int kind, bit inv, bit mark_ok, int lock_exp, string tag);
        logic [27:0] fb;
        logic [23:0] sent;
        sent  = inv ? ~t : t;
        fb[0] = mark_ok;
        for (int i = 0; i < 24; i++) fb[1+i] = sent[i];
        fb[25] = (kind == 0) ? ~^t : ^t;
        fb[26] = inv;
        fb[27] = 1'b0;
        for (int i = 0; i < FL; i++) begin
            if (i == 2 && lock_exp >= 0) chk(tag, 32'(frm_lock), 32'(lock_exp));
            step(fb[i]);
        end
    endtask

    task automatic rand_active(int n);
        for (int f = 0; f < n; f++)
            send_frame(24'($urandom), 0, 1'($urandom), 1'b1, -1, "");
    endtask

    bit done = 0;

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired [%s]", scen);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < FL; k++) begin
            hist.push_back(0);
            cand[k] = 0;
        end
        repeat (3) @(negedge clk);
        compare_all();
        chk("R10 reset lock", 32'(frm_lock), 32'd0);
        rst_n = 1'b1;
        ser_bit = 1'b0;
        model_edge(1'b0);

        scen = "R3 broken run";
        for (int j = 0; j < 37; j++) step(1'($urandom));
        rand_active(20);
        send_frame(24'($urandom), 0, 1'b0, 1'b0, -1, "");
        rand_active(31);
        send_frame(24'h5A5A5A, 0, 1'b0, 1'b1, 0, "R3 no lock after 31");
        send_frame(24'h123456, 0, 1'b1, 1'b1, 1, "R2 lock after 32");

        scen = "R1 R5 R6 active data";
        send_frame(24'hFFFFFF, 0, 1'b0, 1'b1, 1, "R6 locked");
        send_frame(24'h000000, 0, 1'b1, 1'b1, -1, "");
        send_frame(24'h800001, 0, 1'b1, 1'b1, -1, "");
        rand_active(10);

        scen = "R7 blanking";
        send_frame(24'h000001, 1, 1'b0, 1'b1, -1, "");
        send_frame(24'h000002, 1, 1'b1, 1'b1, -1, "");
        send_frame(24'h000003, 1, 1'b0, 1'b1, -1, "");
        send_frame(24'h000000, 1, 1'b1, 1'b1, -1, "");
        rand_active(2);

        scen = "R8 corrupt";
        send_frame(24'h000004, 2, 1'b0, 1'b1, -1, "");
        send_frame(24'hF00000, 2, 1'b1, 1'b1, -1, "");
        send_frame(24'h000003, 1, 1'b0, 1'b1, -1, "");
        send_frame(24'h800000, 2, 1'b0, 1'b1, -1, "");
        rand_active(2);

        scen = "R11 R4 three misses";
        for (int f = 0; f < MISSN - 1; f++)
            send_frame(24'($urandom), 0, 1'b0, 1'b0, -1, "");
        send_frame(24'hABCDEF, 0, 1'b0, 1'b1, 1, "R4 lock kept");
        send_frame(24'h0F0F0F, 0, 1'b1, 1'b1, 1, "R4 lock kept");

        scen = "R4 four misses";
        for (int f = 0; f < MISSN; f++)
            send_frame(24'($urandom), 0, 1'b0, 1'b0, -1, "");
        send_frame(24'h111111, 0, 1'b0, 1'b1, 0, "R4 lock lost");

        scen = "R9 unlocked hold";
        send_frame(24'h000003, 1, 1'b0, 1'b1, 0, "R9 still searching");
        send_frame(24'h000004, 2, 1'b0, 1'b1, 0, "R9 still searching");
        rand_active(8);

        scen = "R2 new offset";
        for (int j = 0; j < 5; j++) step(1'($urandom));
        rand_active(31);
        send_frame(24'h00FF00, 0, 1'b0, 1'b1, 0, "R2 not yet");
        send_frame(24'h13579B, 0, 1'b1, 1'b1, 1, "R2 relocked");
        send_frame(24'h000002, 1, 1'b0, 1'b1, 1, "R2 relocked");
        rand_active(4);
        step(1'b0);
        step(1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule